// File: doc/BRIEF.md
# Device Configuration Sequencing Controller

This controller steps a programmable device from power-up to user operation. It waits until both supply-good flags are high. It then clears configuration memory for a fixed number of cycles, and during that time it pulls a shared open-drain ready line low. When clearing ends it lets the line go. It latches the boot mode pins at the moment the line is seen high. It then takes configuration words from a valid/data/last stream and keeps a running check value. The final word of the stream carries the expected value.

On a match, three start-up steps follow on consecutive clock edges, and then the controller sits in user operation. On a mismatch it pulls the ready line low again to flag the error, and it waits there. Pulling the active-low restart input low at any time sends the controller back to clearing.

An outside agent can stretch clearing in two ways: by holding the restart input low, or by holding the ready line low after the controller has let it go. The controller reads back the wired line value to see that second kind of hold.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset the ready line is pulled low, and cfg_complete, state_reset_release, user_io_en and boot_mode_q are all 0. Nothing moves on while either supply flag is low.
- R2: The clock edge that first sees both supply flags high starts clearing. The ready line stays pulled low through CLEAR_CYCLES further edges and is let go on edge CLEAR_CYCLES+1 counted from that first edge.
- R3: While restart_n is low the ready line stays pulled low and the clearing count stays at zero. The ready line is let go CLEAR_CYCLES edges after the last edge that saw restart_n low.
- R4: After the line is let go, a low level read back on rdy_line_in holds the controller in its waiting step. In that step the mode is not latched and no word is taken.
- R5: boot_mode_pins is captured into boot_mode_q on the edge where the let-go ready line first reads high. Later changes on the pins have no effect until the next clearing pass.
- R6: Words presented while clearing or while the ready line is held low do not enter the check value.
- R7: The check value starts at all ones and is reset whenever clearing is active. Each accepted word d with cfg_last=0 updates it to ((c<<1) XOR (c[MSB] ? CRC_POLY : 0)) XOR d, where CRC_POLY defaults to 16'h1021. The word with cfg_last=1 is the expected value and is not folded in.
- R8: If the last word differs from the check value, the ready line is pulled low from the next edge on. The three start-up outputs stay 0 until restart_n is pulled low.
- R9: On a match, state_reset_release rises on the edge that takes the last word, cfg_complete rises one edge later, and user_io_en rises one edge after that.
- R10: One edge with restart_n low, including during user operation, clears all three start-up outputs and pulls the ready line low.
- R11: Words presented after the last word has been taken have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_core_ok | input | 1 | Core supply good |
| vcc_io_ok | input | 1 | I/O supply good |
| restart_n | input | 1 | Active-low restart request, level sensitive |
| rdy_line_in | input | 1 | Wired value of the open-drain ready line |
| boot_mode_pins | input | MODE_W | Boot mode pins |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_data | input | DATA_W | Configuration word |
| cfg_last | input | 1 | Word is the expected check value |
| rdy_line_pull_low | output | 1 | Pull the ready line low when 1, let it go when 0 |
| cfg_complete | output | 1 | Configuration finished |
| state_reset_release | output | 1 | Global state reset released |
| user_io_en | output | 1 | User I/O enabled |
| boot_mode_q | output | MODE_W | Latched boot mode |

## Verification
The bench builds the block with CLEAR_CYCLES=8, DATA_W=16 and MODE_W=3. The short clearing count makes it cheap to measure the release edge exactly, and to repeat that measurement after each restart, each hold and each failed load. The 16-bit width with the default polynomial means that streams of several lengths and seeds carry bits across the MSB feedback. It also means that an expected value changed by a single bit must be caught as a mismatch.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT = 3'd0,
        ST_CLEAR    = 3'd1,
        ST_RELEASE  = 3'd2,
        ST_LOAD     = 3'd3,
        ST_STARTUP  = 3'd4,
        ST_USER     = 3'd5,
        ST_FAIL     = 3'd6
    } cfg_state_e;

    typedef struct packed {
        logic srel;
        logic complete;
        logic io_en;
    } su_flags_t;

    localparam su_flags_t SU_NONE = '{srel: 1'b0, complete: 1'b0, io_en: 1'b0};

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic pulls_line(input cfg_state_e s);
        return (s == ST_PWR_WAIT) || (s == ST_CLEAR) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int CW = cfg_seq_pkg::cnt_width(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_crc_accum.sv
module cfg_crc_accum #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021,
    parameter logic [W-1:0]    SEED = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step_en,
    input  logic [W-1:0] word,
    output logic [W-1:0] value
);
    function automatic logic [W-1:0] next_val(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] sh;
        sh = {c[W-2:0], 1'b0};
        if (c[W-1]) begin
            sh = sh ^ POLY;
        end
        return sh ^ d;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value <= SEED;
        end else if (step_en) begin
            value <= next_val(value, word);
        end
    end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      start,
    output su_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flags <= SU_NONE;
        end else begin
            flags.srel     <= flags.srel | start;
            flags.complete <= flags.complete | flags.srel;
            flags.io_en    <= flags.io_en | flags.complete;
        end
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int                  DATA_W       = 16,
    parameter int                  MODE_W       = 3,
    parameter int                  CLEAR_CYCLES = 64,
    parameter logic [DATA_W-1:0]   CRC_POLY     = 16'h1021,
    parameter logic [DATA_W-1:0]   CRC_SEED     = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vcc_core_ok,
    input  logic              vcc_io_ok,
    input  logic              restart_n,
    input  logic              rdy_line_in,
    input  logic [MODE_W-1:0] boot_mode_pins,
    input  logic              cfg_valid,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              cfg_last,
    output logic              rdy_line_pull_low,
    output logic              cfg_complete,
    output logic              state_reset_release,
    output logic              user_io_en,
    output logic [MODE_W-1:0] boot_mode_q
);
    cfg_state_e        state_q, state_d;
    logic              clr_expired;
    logic              clr_restart;
    logic [DATA_W-1:0] crc_val;
    logic              crc_step;
    logic              su_start;
    logic              mode_take;
    su_flags_t         su_flags;

    // Keep the clearing count at zero outside clearing and while restart is held.
    assign clr_restart = (state_q != ST_CLEAR) || !restart_n;

    cfg_clear_timer #(.CYCLES(CLEAR_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (clr_restart),
        .expired (clr_expired)
    );

    cfg_crc_accum #(.W(DATA_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q == ST_CLEAR),
        .step_en (crc_step),
        .word    (cfg_data),
        .value   (crc_val)
    );

    cfg_startup_seq u_su (
        .clk   (clk),
        .rst   (rst),
        .clear (state_d == ST_CLEAR),
        .start (su_start),
        .flags (su_flags)
    );

    always_comb begin
        state_d   = state_q;
        crc_step  = 1'b0;
        su_start  = 1'b0;
        mode_take = 1'b0;
        if (!restart_n && state_q != ST_PWR_WAIT) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_PWR_WAIT: if (vcc_core_ok && vcc_io_ok) state_d = ST_CLEAR;
                ST_CLEAR:    if (clr_expired) state_d = ST_RELEASE;
                ST_RELEASE: begin
                    // Line let go; an outside hold keeps the wired value low.
                    if (rdy_line_in) begin
                        mode_take = 1'b1;
                        state_d   = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (cfg_valid) begin
                        if (!cfg_last) begin
                            crc_step = 1'b1;
                        end else if (cfg_data == crc_val) begin
                            su_start = 1'b1;
                            state_d  = ST_STARTUP;
                        end else begin
                            state_d  = ST_FAIL;
                        end
                    end
                end
                ST_STARTUP:  if (su_flags.io_en) state_d = ST_USER;
                ST_USER:     state_d = ST_USER;
                ST_FAIL:     state_d = ST_FAIL;
                default:     state_d = ST_PWR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PWR_WAIT;
            boot_mode_q <= '0;
        end else begin
            state_q <= state_d;
            if (mode_take) begin
                boot_mode_q <= boot_mode_pins;
            end
        end
    end

    assign rdy_line_pull_low   = pulls_line(state_q);
    assign state_reset_release = su_flags.srel;
    assign cfg_complete        = su_flags.complete;
    assign user_io_en          = su_flags.io_en;
endmodule

// File: rtl/cfg_seq_checker.sv
module cfg_seq_checker (
    input logic clk,
    input logic rst,
    input logic restart_n,
    input logic rdy_line_pull_low,
    input logic cfg_complete,
    input logic state_reset_release,
    input logic user_io_en
);
    assert_complete_after_srel_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_complete) |-> $past(state_reset_release));

    assert_io_after_complete_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(user_io_en) |-> $past(cfg_complete));

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !restart_n |=> (!cfg_complete && !user_io_en && !state_reset_release && rdy_line_pull_low));

    assert_complete_line_free_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_complete |-> !rdy_line_pull_low);

    assert_io_needs_all_R9: assert property (@(posedge clk) disable iff (rst)
        user_io_en |-> (cfg_complete && state_reset_release));
endmodule

bind cfg_seq_ctrl cfg_seq_checker u_cfg_seq_checker (
    .clk                 (clk),
    .rst                 (rst),
    .restart_n           (restart_n),
    .rdy_line_pull_low   (rdy_line_pull_low),
    .cfg_complete        (cfg_complete),
    .state_reset_release (state_reset_release),
    .user_io_en          (user_io_en)
);

// File: tb/cfg_seq_ctrl_bench.sv
module cfg_seq_ctrl_bench;
    localparam int DW   = 16;
    localparam int MW   = 3;
    localparam int NCLR = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          core_ok = 1'b0, io_ok = 1'b0, restart_n = 1'b1, ext_hold = 1'b0;
    logic          f_valid = 1'b0, f_last = 1'b0;
    logic [DW-1:0] f_data = '0;
    logic [MW-1:0] mode_in = '0;
    logic          rdy_line;
    logic          pull_low, complete, srel, ioen;
    logic [MW-1:0] mode_q;

    assign rdy_line = ~pull_low & ~ext_hold;

    cfg_seq_ctrl #(.DATA_W(DW), .MODE_W(MW), .CLEAR_CYCLES(NCLR)) u_cfg_seq_ctrl (
        .clk(clk), .rst(rst), .vcc_core_ok(core_ok), .vcc_io_ok(io_ok),
        .restart_n(restart_n), .rdy_line_in(rdy_line), .boot_mode_pins(mode_in),
        .cfg_valid(f_valid), .cfg_data(f_data), .cfg_last(f_last),
        .rdy_line_pull_low(pull_low), .cfg_complete(complete),
        .state_reset_release(srel), .user_io_en(ioen), .boot_mode_q(mode_q)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (pull_low && n < 1000) begin
            tick(1);
            n++;
        end
    endtask

    function automatic logic [DW-1:0] model_step(input logic [DW-1:0] c, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = c << 1;
        if (c[DW-1]) r = r ^ 16'h1021;
        return r ^ d;
    endfunction

    task automatic send_word(input logic [DW-1:0] d, input logic last);
        f_valid = 1'b1;
        f_data  = d;
        f_last  = last;
        tick(1);
        f_valid = 1'b0;
        f_last  = 1'b0;
        f_data  = '0;
    endtask

    // Sends cnt body words then the expected value; bad flips bit 0 of it.
    task automatic send_stream(input int cnt, input logic [DW-1:0] base, input bit bad);
        logic [DW-1:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < cnt; i++) begin
            logic [DW-1:0] w;
            w = base + DW'(i * 16'h1357);
            c = model_step(c, w);
            send_word(w, 1'b0);
        end
        send_word(bad ? (c ^ 16'h0001) : c, 1'b1);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "line pulled in reset", longint'(pull_low), 1);
        chk("R1", "startup outputs in reset", longint'({srel, complete, ioen}), 0);
        chk("R1", "mode in reset", longint'(mode_q), 0);
        rst = 1'b0;
        core_ok = 1'b1;
        tick(12);
        chk("R1", "line pulled with one supply", longint'(pull_low), 1);
        chk("R1", "no release with one supply", longint'(srel), 0);
    endtask

    task automatic t_powerup;
        int n;
        mode_in = 3'b011;
        io_ok = 1'b1;
        wait_release(n);
        chk("R2", "edges to release", n, NCLR + 1);
        tick(1);
        chk("R5", "mode latched", longint'(mode_q), 3'b011);
    endtask

    task automatic t_good_load(input int cnt, input logic [DW-1:0] base);
        send_stream(cnt, base, 1'b0);
        chk("R9", "step1 {srel,complete,io}", longint'({srel, complete, ioen}), 3'b100);
        tick(1);
        chk("R9", "step2 {srel,complete,io}", longint'({srel, complete, ioen}), 3'b110);
        tick(1);
        chk("R7", "match reaches user io", longint'({srel, complete, ioen}), 3'b111);
        chk("R8", "line free after match", longint'(pull_low), 0);
    endtask

    task automatic t_user_ignore;
        send_word(16'hDEAD, 1'b0);
        send_word(16'hBEEF, 1'b1);
        tick(2);
        chk("R11", "outputs after late words", longint'({pull_low, srel, complete, ioen}), 4'b0111);
    endtask

    task automatic t_restart_user;
        int n;
        restart_n = 1'b0;
        tick(1);
        chk("R10", "outputs after restart edge", longint'({pull_low, srel, complete, ioen}), 4'b1000);
        tick(4);
        chk("R3", "line held while restart low", longint'(pull_low), 1);
        restart_n = 1'b1;
        wait_release(n);
        chk("R3", "edges to release after restart", n, NCLR);
        tick(1);
    endtask

    task automatic t_bad_crc;
        int n;
        send_stream(4, 16'h0F0F, 1'b1);
        chk("R8", "line pulled on mismatch", longint'(pull_low), 1);
        tick(6);
        chk("R8", "no startup after mismatch", longint'({srel, complete, ioen}), 0);
        chk("R8", "line still pulled", longint'(pull_low), 1);
        restart_n = 1'b0;
        tick(1);
        restart_n = 1'b1;
        wait_release(n);
        chk("R3", "release after fail restart", n, NCLR);
        tick(1);
    endtask

    task automatic t_hold;
        int n;
        restart_n = 1'b0;
        tick(2);
        send_word(16'h5555, 1'b0);
        send_word(16'hAAAA, 1'b0);
        ext_hold = 1'b1;
        mode_in  = 3'b101;
        restart_n = 1'b1;
        wait_release(n);
        chk("R3", "release with line hold pending", n, NCLR);
        send_word(16'h1111, 1'b0);
        send_word(16'h2222, 1'b0);
        send_word(16'h3333, 1'b1);
        tick(3);
        chk("R4", "mode kept during line hold", longint'(mode_q), 3'b011);
        chk("R4", "no startup during hold", longint'({srel, complete, ioen}), 0);
        mode_in  = 3'b110;
        ext_hold = 1'b0;
        tick(1);
        chk("R5", "mode on line rise", longint'(mode_q), 3'b110);
        mode_in = 3'b001;
        tick(3);
        chk("R5", "mode ignores later pins", longint'(mode_q), 3'b110);
        t_good_load(3, 16'hC001);
        chk("R6", "early words ignored, load matched", longint'(complete), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup();
        t_good_load(5, 16'h1234);
        t_user_ignore();
        t_restart_user();
        t_bad_crc();
        t_hold();
        t_restart_user();
        t_good_load(9, 16'h8F00);
        chk("R5", "mode after relatch", longint'(mode_q), 3'b001);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule